// File: doc/BRIEF.md
# Byte-Lane Load/Store Bus Master

This block is the memory-access stage of an in-order core, facing the data bus. The core hands it one load or store at a time: a byte address, an access size (byte, halfword or word), a sign flag for loads and the store data. The block registers the request and drives it onto a single-outstanding bus. That bus has a one-cycle address strobe, separate read and write qualifiers and four byte-lane enables. It then waits for the slave's ready. Stores of less than a word set only the matching lane enables and copy the data into those lanes, so the memory is never read back to merge bytes. Loads always fetch the whole word, and the block picks and extends the wanted lane itself.

While an access is on the bus, a stall output is held high so that the pipeline freezes. The time spent is fixed by the slave and not by the data. After each completion the address strobe stays low for one cycle before the next access can start. Only naturally aligned accesses are issued. The slave's wait and error inputs are accepted but have no effect.

Top module: `ldst_bus_master`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, stall, busAddrStrobe, busRdStrobe, busWrStrobe and loadValid are all low.
- R2: A request with reqValid high in a cycle where stall is low is accepted at that clock edge. In the next cycle busAddrStrobe is high for exactly that one cycle, stall is high, and busAddr carries the unmodified byte address. busWrStrobe is high for a store (reqWrite=1) and busRdStrobe is high for a load (reqWrite=0). The qualifier stays high until the access completes.
- R3: From the strobe cycle until ready is sampled, busAddr, busWdata and busByteEn hold their values. Any request input presented while stall is high is ignored.
- R4: busReady is sampled only from the cycle after the strobe onward. Ready in the strobe cycle itself is ignored. stall stays high through the cycle in which ready is sampled high and is low in the next cycle.
- R5: Size encoding on reqSize is 2'b00 byte, 2'b01 halfword and 2'b10 word (2'b11 acts as word). For a store, the byte enables are set as follows. A byte store sets only bit n of busByteEn, where n equals address bits [1:0]. A halfword store uses 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A word store uses 4'b1111.
- R6: Store data is placed as follows. A byte store copies reqWdata[7:0] into all four byte lanes of busWdata. A halfword store copies reqWdata[15:0] into both halves. A word store passes reqWdata unchanged.
- R7: Every load is a full-word read: busByteEn is 4'b1111 for any load size.
- R8: For a load, loadValid is high for exactly one cycle, the cycle after ready was sampled, and loadData is valid in that cycle. A byte load returns lane n of busRdata, where n equals address bits [1:0]. A halfword load returns bits [15:0] when address bit 1 is 0 and bits [31:16] when it is 1. The selected lane is sign-extended when reqSigned=1 and zero-extended otherwise. A word load returns the full word. Stores never raise loadValid.
- R9: After a completion, busAddrStrobe is low for one cycle. A request presented in that cycle puts its strobe on the bus in the following cycle.
- R10: The busWait, busCorrErr and busUncorrErr inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 store, 0 load |
| reqSize | input | 2 | 00 byte, 01 halfword, 10 word |
| reqSigned | input | 1 | Sign-extend load result |
| reqAddr | input | 32 | Byte address (aligned) |
| reqWdata | input | 32 | Store data, right-aligned |
| stall | output | 1 | Access in flight, freeze pipeline |
| loadValid | output | 1 | Load result valid (one cycle) |
| loadData | output | 32 | Extended load result |
| busAddr | output | 32 | Bus byte address |
| busWdata | output | 32 | Bus write data, lane-replicated |
| busRdStrobe | output | 1 | Read access qualifier |
| busWrStrobe | output | 1 | Write access qualifier |
| busAddrStrobe | output | 1 | One-cycle address strobe |
| busByteEn | output | 4 | Byte-lane enables |
| busRdata | input | 32 | Bus read word |
| busReady | input | 1 | Slave completion |
| busWait | input | 1 | Slave wait indication (ignored) |
| busCorrErr | input | 1 | Correctable error (ignored) |
| busUncorrErr | input | 1 | Uncorrectable error (ignored) |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 32-bit data path, so there are four byte lanes. This width covers every lane position for byte stores and byte loads, both halfword positions, and sign and zero extension of a negative lane. A bus-side slave model returns ready after a chosen number of wait cycles. This exercises the zero-wait case, long holds, ready raised early in the strobe cycle, and back-to-back accesses through the one-cycle gap.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } accSize_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } busState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;   // register a new request
    logic capLoad;  // register the extracted load result
  } dpCtl_t;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   busReady,
  output logic   stall,
  output logic   busAddrStrobe,
  output logic   busRdStrobe,
  output logic   busWrStrobe,
  output logic   loadValid,
  output dpCtl_t dpCtl
);

  busState_e state, stateNext;
  logic      isWrite;
  logic      done;

  assign done = (state == ST_WAIT) && busReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_ISSUE;
      ST_ISSUE: stateNext = ST_WAIT;  // ready not sampled in strobe cycle
      ST_WAIT:  if (busReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      isWrite   <= 1'b0;
      loadValid <= 1'b0;
    end else begin
      state     <= stateNext;
      loadValid <= done && !isWrite;
      if (dpCtl.capReq) isWrite <= reqWrite;
    end
  end

  assign stall         = (state != ST_IDLE);
  assign busAddrStrobe = (state == ST_ISSUE);
  assign busRdStrobe   = stall && !isWrite;
  assign busWrStrobe   = stall && isWrite;

  assign dpCtl.capReq  = (state == ST_IDLE) && reqValid;
  assign dpCtl.capLoad = done && !isWrite;

  // R2: address strobe lasts one cycle only
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    busAddrStrobe |=> !busAddrStrobe);

  // R4: strobe cycle is always a stalled cycle
  a_r4_strobe_stalls: assert property (@(posedge clk) disable iff (rst)
    busAddrStrobe |-> stall);

  // R4: sampled ready releases stall on the next cycle
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (stall && busReady && !busAddrStrobe) |=> !stall);

  // R9: no strobe in the cycle after a completion
  a_r9_gap: assert property (@(posedge clk) disable iff (rst)
    (stall && busReady && !busAddrStrobe) |=> !busAddrStrobe);

  // R8: load result pulse is one cycle wide
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    loadValid |=> !loadValid);

endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpCtl_t               dpCtl,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  logic                 reqSigned,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    busRdata,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W/8-1:0]  busByteEn,
  output logic [DATA_W-1:0]    loadData
);

  localparam int NLANES    = DATA_W / 8;
  localparam int LANE_BITS = $clog2(NLANES);
  localparam logic [NLANES-1:0] LANE_ONE  = {{(NLANES-1){1'b0}}, 1'b1};
  localparam logic [NLANES-1:0] LANE_PAIR = {{(NLANES-2){1'b0}}, 2'b11};

  accSize_e reqSz, sizeQ;
  logic [ADDR_W-1:0]    addrQ;
  logic [DATA_W-1:0]    wdataQ, replWdata, loadQ;
  logic [NLANES-1:0]    beQ, beNext;
  logic                 signedQ;
  logic [LANE_BITS-1:0] reqLane, laneQ;
  logic [DATA_W-1:0]    shifted, extracted;

  assign reqSz   = accSize_e'(reqSize);
  assign reqLane = reqAddr[LANE_BITS-1:0];

  // Store data replication per lane
  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    assign replWdata[8*i +: 8] =
      (reqSz == SZ_BYTE) ? reqWdata[7:0] :
      (reqSz == SZ_HALF) ? reqWdata[8*(i%2) +: 8] :
                           reqWdata[8*i +: 8];
  end

  always_comb begin
    if (!reqWrite) begin
      beNext = '1;
    end else begin
      unique case (reqSz)
        SZ_BYTE: beNext = LANE_ONE << reqLane;
        SZ_HALF: beNext = LANE_PAIR << {reqLane[LANE_BITS-1:1], 1'b0};
        default: beNext = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      beQ     <= '0;
      sizeQ   <= SZ_WORD;
      signedQ <= 1'b0;
    end else if (dpCtl.capReq) begin
      addrQ   <= reqAddr;
      wdataQ  <= replWdata;
      beQ     <= beNext;
      sizeQ   <= reqSz;
      signedQ <= reqSigned;
    end
  end

  // Load lane select and extension
  assign laneQ   = addrQ[LANE_BITS-1:0];
  assign shifted = busRdata >> {laneQ, 3'b000};

  always_comb begin
    unique case (sizeQ)
      SZ_BYTE: extracted = {{(DATA_W-8){signedQ & shifted[7]}}, shifted[7:0]};
      SZ_HALF: extracted = {{(DATA_W-16){signedQ & shifted[15]}}, shifted[15:0]};
      default: extracted = busRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) loadQ <= '0;
    else if (dpCtl.capLoad) loadQ <= extracted;
  end

  assign busAddr   = addrQ;
  assign busWdata  = wdataQ;
  assign busByteEn = beQ;
  assign loadData  = loadQ;

  // R5: a captured request never leaves all lanes disabled
  a_r5_lanes_set: assert property (@(posedge clk) disable iff (rst)
    $past(dpCtl.capReq) |-> (busByteEn != '0));

endmodule

// File: rtl/ldst_bus_master.sv
module ldst_bus_master
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [1:0]          reqSize,
  input  logic                reqSigned,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                stall,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadData,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busWdata,
  output logic                busRdStrobe,
  output logic                busWrStrobe,
  output logic                busAddrStrobe,
  output logic [DATA_W/8-1:0] busByteEn,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                busReady,
  input  logic                busWait,
  input  logic                busCorrErr,
  input  logic                busUncorrErr
);

  dpCtl_t dpCtl;
  logic   sinkUnused;

  // R10: slave wait and error indications are not used
  assign sinkUnused = ^{busWait, busCorrErr, busUncorrErr};

  ldst_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .busReady     (busReady),
    .stall        (stall),
    .busAddrStrobe(busAddrStrobe),
    .busRdStrobe  (busRdStrobe),
    .busWrStrobe  (busWrStrobe),
    .loadValid    (loadValid),
    .dpCtl        (dpCtl)
  );

  ldst_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dpCtl    (dpCtl),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqSigned(reqSigned),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busByteEn(busByteEn),
    .loadData (loadData)
  );

  // R3: bus request fields hold while the access is pending
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    ((busRdStrobe || busWrStrobe) && !(busReady && !busAddrStrobe))
      |=> ($stable(busAddr) && $stable(busWdata) && $stable(busByteEn)));

  // R7: loads always enable every lane
  a_r7_full_word: assert property (@(posedge clk) disable iff (rst)
    busRdStrobe |-> (busByteEn == '1));

  // R2: read and write qualifiers never together
  a_r2_one_dir: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busRdStrobe, busWrStrobe}));

endmodule

// File: tb/tb_ldst_bus_master.sv
module tb_ldst_bus_master;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSigned = 1'b0;
  logic [1:0]  reqSize = 2'b10;
  logic [31:0] reqAddr = '0, reqWdata = '0, busRdata = '0;
  logic        busReady = 1'b0, busWait = 1'b0, busCorrErr = 1'b0, busUncorrErr = 1'b0;
  logic        stall, loadValid, busRdStrobe, busWrStrobe, busAddrStrobe;
  logic [31:0] loadData, busAddr, busWdata;
  logic [3:0]  busByteEn;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_bus_master dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .stall(stall), .loadValid(loadValid),
    .loadData(loadData), .busAddr(busAddr), .busWdata(busWdata),
    .busRdStrobe(busRdStrobe), .busWrStrobe(busWrStrobe),
    .busAddrStrobe(busAddrStrobe), .busByteEn(busByteEn),
    .busRdata(busRdata), .busReady(busReady), .busWait(busWait),
    .busCorrErr(busCorrErr), .busUncorrErr(busUncorrErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expBe(input logic wr, input logic [1:0] sz,
                                       input logic [31:0] a);
    if (!wr) return 4'b1111;                              // R7
    if (sz == 2'b00) return 4'b0001 << a[1:0];            // R5
    if (sz == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] expWd(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'b00) return {4{d[7:0]}};                  // R6
    if (sz == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] expLd(input logic [1:0] sz, input logic sg,
                                        input logic [31:0] a, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*a[1:0] +: 8];
    h = a[1] ? w[31:16] : w[15:0];
    if (sz == 2'b00) return sg ? {{24{b[7]}}, b} : {24'h0, b};   // R8
    if (sz == 2'b01) return sg ? {{16{h[15]}}, h} : {16'h0, h};
    return w;
  endfunction

  // One access with a slave that waits `waits` cycles after the strobe cycle.
  task automatic access(input logic wr, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [31:0] wd,
                        input logic [31:0] rword, input int waits, input logic early);
    logic [3:0]  be;
    logic [31:0] wdx;
    be  = expBe(wr, sz, a);
    wdx = expWd(sz, wd);
    // at negedge, stall low: present request
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqSigned = sg;
    reqAddr = a; reqWdata = wd;
    @(negedge clk);
    // strobe cycle (R9: strobe arrives one cycle after the gap-cycle request)
    check(busAddrStrobe === 1'b1, "R2/R9 strobe", {31'b0, busAddrStrobe}, 32'h1);
    check(stall === 1'b1, "R2 stall", {31'b0, stall}, 32'h1);
    check(busAddr === a, "R2 addr", busAddr, a);
    check(busWrStrobe === wr && busRdStrobe === !wr, "R2 qualifier",
          {30'b0, busRdStrobe, busWrStrobe}, {30'b0, !wr, wr});
    check(busByteEn === be, wr ? "R5 byte enable" : "R7 byte enable",
          {28'b0, busByteEn}, {28'b0, be});
    if (wr) check(busWdata === wdx, "R6 store data", busWdata, wdx);
    // R3: scramble request inputs while stalled
    reqAddr = ~a; reqWdata = ~wd; reqSize = ~sz; reqWrite = ~wr;
    busReady = early;   // R4: ready in strobe cycle must be ignored
    busRdata = early ? ~rword : rword;
    @(negedge clk);
    check(stall === 1'b1, "R4 early ready ignored", {31'b0, stall}, 32'h1);
    busReady = 1'b0;
    for (int k = 0; k < waits; k++) begin
      check(busAddrStrobe === 1'b0, "R2 single strobe", {31'b0, busAddrStrobe}, 32'h0);
      check(stall === 1'b1, "R3 stall held", {31'b0, stall}, 32'h1);
      check(busAddr === a && busByteEn === be, "R3 hold addr", busAddr, a);
      if (wr) check(busWdata === wdx, "R3 hold data", busWdata, wdx);
      @(negedge clk);
    end
    reqValid = 1'b0;
    busReady = 1'b1; busRdata = rword;
    check(stall === 1'b1, "R4 stall in ready cycle", {31'b0, stall}, 32'h1);
    check(busAddr === a, "R3 addr at ready", busAddr, a);
    @(negedge clk);
    busReady = 1'b0; busRdata = 32'hDEAD_BEEF;
    check(stall === 1'b0, "R4 stall released", {31'b0, stall}, 32'h0);
    check(busAddrStrobe === 1'b0, "R9 gap", {31'b0, busAddrStrobe}, 32'h0);
    check(loadValid === !wr, "R8 loadValid", {31'b0, loadValid}, {31'b0, !wr});
    if (!wr) check(loadData === expLd(sz, sg, a, rword), "R8 loadData",
                   loadData, expLd(sz, sg, a, rword));
    // gap cycle: stay here; next access presents its request now
  endtask

  task automatic t_reset();
    check(stall === 1'b0 && busAddrStrobe === 1'b0 && busRdStrobe === 1'b0 &&
          busWrStrobe === 1'b0 && loadValid === 1'b0, "R1 reset outputs",
          {27'b0, stall, busAddrStrobe, busRdStrobe, busWrStrobe, loadValid}, 32'h0);
  endtask

  task automatic t_stores();
    access(1'b1, 2'b10, 1'b0, 32'h1000_0010, 32'h1234_5678, 32'h0, 0, 1'b0);
    for (int l = 0; l < 4; l++)
      access(1'b1, 2'b00, 1'b0, 32'h1000_0020 + l, 32'hAABB_CC00 + l, 32'h0, 1, 1'b0);
    access(1'b1, 2'b01, 1'b0, 32'h1000_0030, 32'h5566_8899, 32'h0, 0, 1'b0);
    access(1'b1, 2'b01, 1'b0, 32'h1000_0032, 32'h0000_F00D, 32'h0, 2, 1'b0);
    access(1'b1, 2'b11, 1'b0, 32'h1000_0034, 32'hCAFE_0001, 32'h0, 0, 1'b0);
  endtask

  task automatic t_loads();
    access(1'b0, 2'b10, 1'b0, 32'h1000_0040, 32'h0, 32'h8765_4321, 3, 1'b0);
    for (int l = 0; l < 4; l++) begin
      access(1'b0, 2'b00, 1'b1, 32'h1000_0050 + l, 32'h0, 32'h80F1_7F92, 0, 1'b0);
      access(1'b0, 2'b00, 1'b0, 32'h1000_0050 + l, 32'h0, 32'h80F1_7F92, 0, 1'b0);
    end
    for (int l = 0; l < 2; l++) begin
      access(1'b0, 2'b01, 1'b1, 32'h1000_0060 + 2*l, 32'h0, 32'h9ABC_7123, 1, 1'b0);
      access(1'b0, 2'b01, 1'b0, 32'h1000_0060 + 2*l, 32'h0, 32'h9ABC_7123, 0, 1'b0);
    end
  endtask

  task automatic t_early_ready();
    access(1'b0, 2'b10, 1'b0, 32'h1000_0070, 32'h0, 32'h0BAD_F00D, 0, 1'b1);
    access(1'b1, 2'b00, 1'b0, 32'h1000_0073, 32'h0000_005A, 32'h0, 0, 1'b1);
  endtask

  task automatic t_ignored_inputs();
    busWait = 1'b1; busCorrErr = 1'b1; busUncorrErr = 1'b1;
    access(1'b0, 2'b00, 1'b1, 32'h1000_0081, 32'h0, 32'h0000_8000, 1, 1'b0);
    access(1'b1, 2'b01, 1'b0, 32'h1000_0082, 32'h0000_1357, 32'h0, 0, 1'b0);
    busWait = 1'b0; busCorrErr = 1'b0; busUncorrErr = 1'b0;
    check(loadValid === 1'b0, "R10 no stray result", {31'b0, loadValid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stores();
    t_loads();
    t_early_ready();
    t_ignored_inputs();
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule